// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block moves bytes between a host-facing data port and a local packet buffer RAM. The host first loads a 16-bit start address and a 16-bit byte count, one byte register at a time. It then writes a command that picks a read or a write transfer and, optionally, word mode. Each strobe on the data port then moves one byte, or two in word mode. After each strobe the address steps up and the count steps down.

When the access that exhausts the count is taken, the engine returns to idle and sets a sticky completion bit. The host clears that bit by writing a one to it. Reads are served from a prefetch register that always holds the buffer word at the current address, so a read strobe can be taken on every cycle. The packet buffer is an inferred 16-bit-wide RAM with byte lanes, and addresses wrap modulo its size.

Top module: `rdma_port`

## Requirements
- R1: After reset every register reads zero: address, count, command and status.
- R2: While idle, register selects 0 and 1 load the low and high byte of the start address, and selects 2 and 3 load the low and high byte of the count. Each reads back at the same select.
- R3: Select 4 is the command register. Bits [1:0] = 01 start a read, 10 start a write, and 00 or 11 abort. Bit 2 selects word mode. Read-back shows {5'b0, word, op}, and op reads 00 whenever the engine is idle.
- R4: In byte mode each accepted strobe moves one byte through dp data bits [7:0], adds 1 to the address and subtracts 1 from the count. On reads, bits [15:8] are zero. The buffer location is the address modulo 2^MEM_AW.
- R5: In word mode each accepted strobe moves two bytes: bits [7:0] go to the even address and bits [15:8] to the next one. The address rises by 2 and the count falls by 2. A final access with only one byte of count left still moves the whole word and completes.
- R6: dp_rdata shows the data at the current address from the cycle after the address settles. It also updates after each read strobe, so read strobes can be issued on back-to-back cycles.
- R7: The clock edge that takes the count to zero also returns op to idle and sets status bit 0. Starting a transfer with a count of zero sets status bit 0 at once and moves no data.
- R8: While idle, or after completion, data-port strobes change neither the address, the count nor the buffer. A strobe in the direction opposite to the active command is also ignored.
- R9: Writing status (select 5) with bit 0 = 1 clears the completion bit. Writing it with bit 0 = 0 leaves the bit unchanged. Setting the bit takes priority over clearing it in the same cycle.
- R10: While a transfer is active, writes to the address and count registers and new read or write commands are ignored. An abort is accepted: it returns op to idle, keeps the address and count, and does not set the completion bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0..5) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_sel |
| dp_rd | input | 1 | Data-port read strobe |
| dp_wr | input | 1 | Data-port write strobe |
| dp_wdata | input | 16 | Data-port write data |
| dp_rdata | output | 16 | Data-port read data (prefetched) |

## Verification
The assertions assume the host behaves as follows:
- It never writes a register in the same cycle as a data-port strobe.
- It never raises dp_rd and dp_wr together.
- In word mode it keeps the address even.

The properties that relate strobes to address steps exclude cycles with a register write, so they do not depend on which of the two wins. The bench drives each task one action per cycle. It starts every word-mode transfer at an even address, so all of its stimulus stays inside these assumptions.

// File: rtl/rdma_port.sv
module rdma_port #(
  parameter int MEM_AW = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_sel,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        dp_rd,
  input  logic        dp_wr,
  input  logic [15:0] dp_wdata,
  output logic [15:0] dp_rdata
);
  localparam int WORDS = 1 << (MEM_AW - 1);
  localparam logic [1:0] OP_IDLE = 2'b00;
  localparam logic [1:0] OP_RD   = 2'b01;
  localparam logic [1:0] OP_WR   = 2'b10;

  logic [15:0] addr, cnt, addr_n, cnt_n;
  logic [1:0]  op, op_n;
  logic        wide, wide_n, done;
  logic [15:0] mem [WORDS];
  logic [15:0] ram_q;

  wire        active     = (op != OP_IDLE);
  wire [15:0] step       = wide ? 16'd2 : 16'd1;
  wire        cmd_wr     = reg_we && (reg_sel == 3'd4);
  wire        req_xfer   = (reg_wdata[1:0] == OP_RD) || (reg_wdata[1:0] == OP_WR);
  wire        abort      = cmd_wr && !req_xfer;
  wire        start      = cmd_wr && req_xfer && !active;
  wire        acc        = active && !abort && (cnt != 16'd0) &&
                           (((op == OP_RD) && dp_rd) || ((op == OP_WR) && dp_wr));
  wire        last       = acc && (cnt <= step);
  wire        zero_start = start && (cnt == 16'd0);
  wire        done_set   = last || zero_start;
  wire        done_clr   = reg_we && (reg_sel == 3'd5) && reg_wdata[0];
  wire [MEM_AW-2:0] widx = addr[MEM_AW-1:1];

  always_comb begin
    addr_n = addr;
    cnt_n  = cnt;
    op_n   = op;
    wide_n = wide;
    if (!active && reg_we) begin
      case (reg_sel)
        3'd0: addr_n[7:0]  = reg_wdata;
        3'd1: addr_n[15:8] = reg_wdata;
        3'd2: cnt_n[7:0]   = reg_wdata;
        3'd3: cnt_n[15:8]  = reg_wdata;
        default: ;
      endcase
    end
    if (abort) begin
      op_n = OP_IDLE;
    end else if (start) begin
      wide_n = reg_wdata[2];
      op_n   = zero_start ? OP_IDLE : reg_wdata[1:0];
    end else if (acc) begin
      addr_n = addr + step;
      cnt_n  = last ? 16'd0 : cnt - step;
      if (last) op_n = OP_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
      cnt  <= '0;
      op   <= OP_IDLE;
      wide <= 1'b0;
      done <= 1'b0;
    end else begin
      addr <= addr_n;
      cnt  <= cnt_n;
      op   <= op_n;
      wide <= wide_n;
      done <= done_set | (done & ~done_clr);
    end
  end

  always_ff @(posedge clk) begin
    if (acc && (op == OP_WR)) begin
      if (wide)         mem[widx]       <= dp_wdata;
      else if (addr[0]) mem[widx][15:8] <= dp_wdata[7:0];
      else              mem[widx][7:0]  <= dp_wdata[7:0];
    end
    ram_q <= mem[addr_n[MEM_AW-1:1]];
  end

  assign dp_rdata = wide ? ram_q : {8'h00, (addr[0] ? ram_q[15:8] : ram_q[7:0])};

  always_comb begin
    case (reg_sel)
      3'd0:    reg_rdata = addr[7:0];
      3'd1:    reg_rdata = addr[15:8];
      3'd2:    reg_rdata = cnt[7:0];
      3'd3:    reg_rdata = cnt[15:8];
      3'd4:    reg_rdata = {5'b0, wide, op};
      3'd5:    reg_rdata = {7'b0, done};
      default: reg_rdata = 8'h00;
    endcase
  end
endmodule

module rdma_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [2:0]  reg_sel,
  input logic [7:0]  reg_wdata,
  input logic        dp_rd,
  input logic        dp_wr,
  input logic [1:0]  op,
  input logic        wide,
  input logic        done,
  input logic [15:0] addr,
  input logic [15:0] cnt
);
  p_active_cnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op != 2'b00) |-> (cnt != 16'd0));

  p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == 3'd5 && reg_wdata[0] && op == 2'b00) |=> !done);

  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(reg_we && reg_sel == 3'd5 && reg_wdata[0])) |=> done);

  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op != 2'b00 && cnt != 16'd0 && !reg_we &&
     ((op == 2'b01 && dp_rd) || (op == 2'b10 && dp_wr)))
    |=> (addr == $past(addr) + ($past(wide) ? 16'd2 : 16'd1)));

  p_cfg_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op != 2'b00 && reg_we && reg_sel < 3'd4 && !dp_rd && !dp_wr)
    |=> ($stable(addr) && $stable(cnt)));

  p_idle_still_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 2'b00 && !reg_we) |=> ($stable(addr) && $stable(cnt)));
endmodule

bind rdma_port rdma_port_chk u_chk (.*);

// File: tb/rdma_port_bench.sv
module rdma_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic        dp_rd = 1'b0;
  logic        dp_wr = 1'b0;
  logic [15:0] dp_wdata = 16'h0000;
  logic [15:0] dp_rdata;

  int nchk = 0;
  int nfail = 0;
  logic [7:0] exp_mem [256];

  always #10 clk = ~clk;

  rdma_port u_rdma_port (.*);

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] s, input logic [7:0] d);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] s, output logic [7:0] v);
    reg_sel = s;
    #1;
    v = reg_rdata;
  endtask

  task automatic setup(input logic [15:0] a, input logic [15:0] c, input logic [7:0] cmd);
    wreg(3'd0, a[7:0]); wreg(3'd1, a[15:8]);
    wreg(3'd2, c[7:0]); wreg(3'd3, c[15:8]);
    wreg(3'd4, cmd);
  endtask

  task automatic chk_regs(input string tag, input logic [15:0] ea, input logic [15:0] ec,
                          input logic [7:0] ecmd, input logic ed);
    logic [7:0] v0, v1;
    rreg(3'd0, v0); rreg(3'd1, v1); chk({tag, " addr"}, {v1, v0}, ea);
    rreg(3'd2, v0); rreg(3'd3, v1); chk({tag, " cnt"}, {v1, v0}, ec);
    rreg(3'd4, v0); chk({tag, " cmd"}, v0, ecmd);
    rreg(3'd5, v0); chk({tag, " done"}, v0, {7'b0, ed});
  endtask

  task automatic xfer_write(input logic [15:0] a, input int n, input logic wd, input int seed);
    int nacc;
    logic [7:0] v;
    nacc = wd ? (n + 1) / 2 : n;
    setup(a, 16'(n), {5'b0, wd, 2'b10});
    for (int k = 0; k < nacc; k++) begin
      if (wd) begin
        dp_wdata = {pat(seed + 2*k + 1), pat(seed + 2*k)};
        exp_mem[(a + 2*k) & 255]     = pat(seed + 2*k);
        exp_mem[(a + 2*k + 1) & 255] = pat(seed + 2*k + 1);
      end else begin
        dp_wdata = {8'h00, pat(seed + k)};
        exp_mem[(a + k) & 255] = pat(seed + k);
      end
      dp_wr = 1'b1;
      if (k == nacc - 1) begin
        rreg(3'd5, v);
        chk("R7 done early", v, 0);
      end
      @(negedge clk);
    end
    dp_wr = 1'b0;
    chk_regs("R7 write end", 16'(a + (wd ? 2*nacc : nacc)), 16'd0, {5'b0, wd, 2'b00}, 1'b1);
  endtask

  task automatic xfer_read(input logic [15:0] a, input int n, input logic wd, input string tag);
    int nacc;
    logic [15:0] e;
    nacc = wd ? (n + 1) / 2 : n;
    setup(a, 16'(n), {5'b0, wd, 2'b01});
    for (int k = 0; k < nacc; k++) begin
      if (wd) e = {exp_mem[(a + 2*k + 1) & 255], exp_mem[(a + 2*k) & 255]};
      else    e = {8'h00, exp_mem[(a + k) & 255]};
      chk(tag, dp_rdata, e);
      dp_rd = 1'b1;
      @(negedge clk);
    end
    dp_rd = 1'b0;
    chk_regs("R7 read end", 16'(a + (wd ? 2*nacc : nacc)), 16'd0, {5'b0, wd, 2'b00}, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int starts [4] = '{1, 5, 200, 255};
    int cnts [4] = '{1, 2, 3, 17};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_regs("R1 reset", 16'h0000, 16'h0000, 8'h00, 1'b0);

    wreg(3'd0, 8'h34); wreg(3'd1, 8'h12); wreg(3'd2, 8'h78); wreg(3'd3, 8'h56);
    chk_regs("R2 load", 16'h1234, 16'h5678, 8'h00, 1'b0);

    xfer_write(16'h0000, 256, 1'b0, 0);
    dp_wr = 1'b1; dp_wdata = 16'h00EE; @(negedge clk); dp_wr = 1'b0;
    chk_regs("R8 strobe after done", 16'h0100, 16'h0000, 8'h00, 1'b1);

    wreg(3'd5, 8'hFE);
    rreg(3'd5, v); chk("R9 write zero keeps", v, 1);
    wreg(3'd5, 8'h01);
    rreg(3'd5, v); chk("R9 write one clears", v, 0);

    xfer_read(16'h0000, 256, 1'b0, "R4 R6 R8 full read");
    foreach (starts[i]) foreach (cnts[j]) begin
      wreg(3'd5, 8'h01);
      xfer_read(16'(starts[i]), cnts[j], 1'b0, "R4 R6 sweep read");
    end

    wreg(3'd5, 8'h01);
    xfer_write(16'h0040, 16, 1'b1, 100);
    wreg(3'd5, 8'h01);
    xfer_read(16'h0040, 16, 1'b1, "R5 word read");
    wreg(3'd5, 8'h01);
    xfer_read(16'h0040, 16, 1'b0, "R5 byte view of words");
    wreg(3'd5, 8'h01);
    xfer_write(16'h0080, 5, 1'b1, 50);
    wreg(3'd5, 8'h01);
    xfer_read(16'h0080, 6, 1'b0, "R5 odd word count");

    wreg(3'd5, 8'h01);
    setup(16'h0010, 16'h0000, 8'h01);
    chk_regs("R7 zero count", 16'h0010, 16'h0000, 8'h00, 1'b1);

    wreg(3'd5, 8'h01);
    setup(16'h0020, 16'h0004, 8'h01);
    wreg(3'd4, 8'h02);
    wreg(3'd0, 8'h99);
    wreg(3'd2, 8'h77);
    chk_regs("R10 locked", 16'h0020, 16'h0004, 8'h01, 1'b0);
    dp_wr = 1'b1; dp_wdata = 16'h00AB; @(negedge clk); dp_wr = 1'b0;
    chk_regs("R8 wrong direction", 16'h0020, 16'h0004, 8'h01, 1'b0);
    for (int k = 0; k < 2; k++) begin
      chk("R8 R6 data after wrong dir", dp_rdata, {8'h00, exp_mem[32 + k]});
      dp_rd = 1'b1; @(negedge clk);
    end
    dp_rd = 1'b0;
    wreg(3'd4, 8'h00);
    chk_regs("R10 abort", 16'h0022, 16'h0002, 8'h00, 1'b0);
    dp_rd = 1'b1; @(negedge clk); dp_rd = 1'b0;
    chk_regs("R8 R3 strobe after abort", 16'h0022, 16'h0002, 8'h00, 1'b0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule